// File: doc/BRIEF.md
# CPU Clock Load-Level Sequencer

This block picks the CPU clock source, divider and alternate-clock select from one of four performance levels, numbered 0 (fastest) to 3 (slowest). Each level's settings sit in one of two 32-bit configuration words, two levels per word. When dynamic mode is off, the block passes static source and divider values through instead. A rate request carries a divide ratio. The block resolves it to a level by searching the levels' divider fields. It then moves the current level, and that level drives the clock mux and divider controls.

The block also guards the supply. When the base clock is fast (1 GHz or more), it never enters level 0 directly from a slow level. It parks at level 1 instead and waits a programmable number of reference cycles for the voltage to settle. A background timer records how long level 1 has been held, so a later move to level 0 can skip the wait once the voltage is known to be stable. Requests that arrive during a forced wait are held and applied when the wait ends.

Top module: `dvfs_seq`

## Requirements
- R1: After a synchronous active-low reset, `cur_level` is 0 and both `busy` and `req_reject` are 0.
- R2: In dynamic mode, the drive outputs come from the field slot of the current level. Levels 0 and 1 read `cfg_low`, and levels 2 and 3 read `cfg_high`. Even levels use bits 31:16 and odd levels use bits 15:0. Inside a slot, the divider is at bits 15:13, the alternate select at bit 11 and the source at bits 10:9.
- R3: With `dyn_en` low, `drv_src` and `drv_div` equal `static_src` and `static_div`, and `drv_alt` is 0. Every request is rejected: `req_reject` is 1 in the cycle after the request, and the level does not change.
- R4: A request resolves to the lowest-numbered level whose divider field equals `req_ratio`. The new level appears in the cycle after the request.
- R5: If no level's divider equals the ratio, `req_reject` pulses for one cycle after the request and the level stays unchanged.
- R6: A request that resolves to the current level changes nothing.
- R7: With `fast_base` high, a request for level 0 without a satisfied dwell changes the level to 1 and raises `busy` in the next cycle. Level 1 then holds for `dwell_len` cycles (a value of 0 counts as 1), after which the level becomes 0 and `busy` clears.
- R8: Entering level 1 from level 2 or 3 starts the dwell timer. Once level 1 has been held for more than `dwell_len` cycles, a level-0 request goes through directly.
- R9: Entering level 1 from level 0 marks the dwell as satisfied, so a later level-0 request goes through directly.
- R10: Moving to level 2 or 3 clears the dwell status. A level-0 request from there takes the forced dwell even if the dwell was satisfied before.
- R11: With `fast_base` low, a level-0 request from any level goes through directly.
- R12: Valid requests made while `busy` is high are held; the newest one replaces older ones. The held request is applied in the cycle after the dwell ends. This includes a request made in the very cycle the dwell expires.
- R13: A level-0 request made while the background timer is still running takes a full forced dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dyn_en | input | 1 | Level-driven mode enable |
| fast_base | input | 1 | Base clock is 1 GHz or faster |
| cfg_low | input | 32 | Settings for levels 0 (upper half) and 1 (lower half) |
| cfg_high | input | 32 | Settings for levels 2 (upper half) and 3 (lower half) |
| static_src | input | 2 | Source select used when dynamic mode is off |
| static_div | input | 3 | Divider used when dynamic mode is off |
| dwell_len | input | CNT_W | Settle time in reference cycles |
| req_valid | input | 1 | Rate request strobe |
| req_ratio | input | 3 | Requested divide ratio |
| cur_level | output | 2 | Active level |
| drv_src | output | 2 | Clock source select to the mux |
| drv_div | output | 3 | Divider value to the divider |
| drv_alt | output | 1 | Alternate clock select |
| busy | output | 1 | Forced dwell in progress |
| req_reject | output | 1 | One-cycle pulse for an unresolvable request |

## Verification
Two functions can meet on the same clock edge: the expiry of a forced dwell, and a newly arriving request. The same applies to background-timer expiry meeting a level-0 request. The bench provokes the first by timing a request so that the design samples it on the exact edge where the dwell count runs out. That request must be held, the level must first drop to 0, and the held level must appear one cycle later. A behavioural reference model keeps the dwell as an absolute deadline, not as a counter, and is compared with every output on every clock. This makes an off-by-one in either collision visible.

// File: rtl/dvfs_seq_pkg.sv
// Package: shared constants and types for the load-level sequencer.
// Assumes four levels packed two per 32-bit word, in half-word slots.
package dvfs_seq_pkg;
    localparam int NUM_LVL   = 4;
    localparam int LVL_W     = $clog2(NUM_LVL);
    localparam int DIV_W     = 3;
    localparam int SRC_W     = 2;
    localparam int SLOT_W    = 16;
    localparam int DIV_LSB   = 13;
    localparam int ALT_BIT   = 11;
    localparam int SRC_LSB   = 9;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             alt;
        logic [SRC_W-1:0] src;
    } lvl_cfg_t;

    typedef enum logic [1:0] {
        DW_NONE = 2'd0,
        DW_RUN  = 2'd1,
        DW_DONE = 2'd2
    } dwell_st_t;

    typedef enum logic {
        SQ_IDLE  = 1'b0,
        SQ_DWELL = 1'b1
    } seq_st_t;
endpackage

// File: rtl/dvfs_lvl_unpack.sv
// Module: splits the two configuration words into per-level settings.
// Assumes levels 0/1 share the low word, even levels take the upper slot.
module dvfs_lvl_unpack
    import dvfs_seq_pkg::*;
(
    input  logic [31:0]                cfg_low,
    input  logic [31:0]                cfg_high,
    output lvl_cfg_t [NUM_LVL-1:0]     tab
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        localparam int OFS = ((l % 2) == 0) ? SLOT_W : 0;
        logic [31:0] word;
        // Purpose: pick the word that holds this level's slot
        assign word = (l < 2) ? cfg_low : cfg_high;
        // Purpose: slice the level's three fields out of its slot
        assign tab[l].div = word[OFS+DIV_LSB +: DIV_W];
        assign tab[l].alt = word[OFS+ALT_BIT];
        assign tab[l].src = word[OFS+SRC_LSB +: SRC_W];
    end
endmodule

// File: rtl/dvfs_ratio_match.sv
// Module: finds the lowest-numbered level whose divider equals the ratio.
// Assumes a purely combinational priority search.
module dvfs_ratio_match
    import dvfs_seq_pkg::*;
(
    input  lvl_cfg_t [NUM_LVL-1:0] tab,
    input  logic [DIV_W-1:0]       ratio,
    output logic                   hit,
    output logic [LVL_W-1:0]       hit_lvl
);
    // Purpose: scan from the top down so the lowest match wins
    always_comb begin
        hit     = 1'b0;
        hit_lvl = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (tab[i].div == ratio) begin
                hit     = 1'b1;
                hit_lvl = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/dvfs_dwell_timer.sv
// Module: counts down a settle window and flags its final cycle.
// Assumes a zero length is treated as one cycle; start wins over stop.
module dvfs_dwell_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] len,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;
    logic             act;

    // Purpose: load, stop or count down the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            act <= 1'b0;
        end else if (start) begin
            cnt <= (len == '0) ? CNT_W'(1) : len;
            act <= 1'b1;
        end else if (stop) begin
            act <= 1'b0;
        end else if (act) begin
            if (cnt <= CNT_W'(1)) act <= 1'b0;
            else                  cnt <= cnt - CNT_W'(1);
        end
    end

    // Purpose: flag the last cycle of an active window
    assign fire = act && (cnt <= CNT_W'(1));
endmodule

// File: rtl/dvfs_seq.sv
// Module: load-level sequencer top; resolves requests, enforces the
// settle dwell before fast entry and drives the clock controls.
// Assumes requests are single-cycle strobes and dwell_len is held steady.
module dvfs_seq
    import dvfs_seq_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dyn_en,
    input  logic             fast_base,
    input  logic [31:0]      cfg_low,
    input  logic [31:0]      cfg_high,
    input  logic [1:0]       static_src,
    input  logic [2:0]       static_div,
    input  logic [CNT_W-1:0] dwell_len,
    input  logic             req_valid,
    input  logic [2:0]       req_ratio,
    output logic [1:0]       cur_level,
    output logic [1:0]       drv_src,
    output logic [2:0]       drv_div,
    output logic             drv_alt,
    output logic             busy,
    output logic             req_reject
);
    lvl_cfg_t [NUM_LVL-1:0] tab;
    lvl_cfg_t               sel;
    logic                   hit, req_hit, fire;
    logic [LVL_W-1:0]       hit_lvl;

    logic [LVL_W-1:0] lvl_q, lvl_d, pend_q, pend_d, app_lvl;
    logic             pend_vld_q, pend_vld_d, app_vld;
    logic             t_start, t_stop;
    dwell_st_t        st_q, st_d;
    seq_st_t          sq_q, sq_d;

    dvfs_lvl_unpack u_unpack (
        .cfg_low  (cfg_low),
        .cfg_high (cfg_high),
        .tab      (tab)
    );

    dvfs_ratio_match u_match (
        .tab     (tab),
        .ratio   (req_ratio),
        .hit     (hit),
        .hit_lvl (hit_lvl)
    );

    dvfs_dwell_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .stop  (t_stop),
        .len   (dwell_len),
        .fire  (fire)
    );

    // Purpose: a request counts only in dynamic mode with a matching level
    assign req_hit = req_valid && dyn_en && hit;
    assign app_vld = req_hit || pend_vld_q;
    assign app_lvl = req_hit ? hit_lvl : pend_q;

    // Purpose: next-state decision for level, dwell status and holding slot
    always_comb begin
        lvl_d      = lvl_q;
        st_d       = st_q;
        sq_d       = sq_q;
        pend_d     = pend_q;
        pend_vld_d = pend_vld_q;
        t_start    = 1'b0;
        t_stop     = 1'b0;
        if (sq_q == SQ_DWELL) begin
            if (req_hit) begin
                pend_vld_d = 1'b1;
                pend_d     = hit_lvl;
            end
            if (fire) begin
                lvl_d  = '0;
                sq_d   = SQ_IDLE;
                st_d   = DW_NONE;
                t_stop = 1'b1;
            end
        end else begin
            pend_vld_d = 1'b0;
            if (st_q == DW_RUN && fire) st_d = DW_DONE;
            if (app_vld && app_lvl != lvl_q) begin
                if (app_lvl == LVL_W'(1)) begin
                    lvl_d = LVL_W'(1);
                    if (lvl_q == '0) begin
                        st_d   = DW_DONE;
                        t_stop = 1'b1;
                    end else begin
                        st_d    = DW_RUN;
                        t_start = 1'b1;
                    end
                end else if (app_lvl != '0) begin
                    lvl_d  = app_lvl;
                    st_d   = DW_NONE;
                    t_stop = 1'b1;
                end else if (!fast_base || st_q == DW_DONE) begin
                    lvl_d  = '0;
                    st_d   = DW_NONE;
                    t_stop = 1'b1;
                end else begin
                    lvl_d   = LVL_W'(1);
                    sq_d    = SQ_DWELL;
                    st_d    = DW_NONE;
                    t_start = 1'b1;
                end
            end
        end
    end

    // Purpose: state registers and the registered reject pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q      <= '0;
            st_q       <= DW_NONE;
            sq_q       <= SQ_IDLE;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            req_reject <= 1'b0;
        end else begin
            lvl_q      <= lvl_d;
            st_q       <= st_d;
            sq_q       <= sq_d;
            pend_q     <= pend_d;
            pend_vld_q <= pend_vld_d;
            req_reject <= req_valid && !(dyn_en && hit);
        end
    end

    // Purpose: select the active level's fields or the static values
    assign sel       = tab[lvl_q];
    assign drv_src   = dyn_en ? sel.src : static_src;
    assign drv_div   = dyn_en ? sel.div : static_div;
    assign drv_alt   = dyn_en ? sel.alt : 1'b0;
    assign cur_level = lvl_q;
    assign busy      = (sq_q == SQ_DWELL);
endmodule

// File: rtl/dvfs_seq_chk.sv
// Module: temporal checks on the sequencer's ports, bound into the top.
// Assumes synchronous active-low reset on rst_n.
module dvfs_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dyn_en,
    input logic       fast_base,
    input logic       req_valid,
    input logic       req_reject,
    input logic       busy,
    input logic [1:0] cur_level
);
    p_dwell_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cur_level == 2'd1);

    p_no_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == 2'd0 && $past(cur_level) >= 2'd2) |-> !$past(fast_base));

    p_dwell_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(fast_base) && $past(cur_level) != 2'd0));

    p_dwell_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cur_level == 2'd0);

    p_static_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dyn_en) |=> req_reject);

    p_reject_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> $past(req_valid));
endmodule

bind dvfs_seq dvfs_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dyn_en     (dyn_en),
    .fast_base  (fast_base),
    .req_valid  (req_valid),
    .req_reject (req_reject),
    .busy       (busy),
    .cur_level  (cur_level)
);

// File: tb/dvfs_seq_test.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module dvfs_seq_test;
    localparam int CW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dyn_en = 1'b0, fast_base = 1'b0;
    logic [31:0]   cfg_low, cfg_high;
    logic [1:0]    static_src = 2'd0;
    logic [2:0]    static_div = 3'd0;
    logic [CW-1:0] dwell_len = CW'(5);
    logic          req_valid = 1'b0;
    logic [2:0]    req_ratio = 3'd0;
    logic [1:0]    cur_level, drv_src;
    logic [2:0]    drv_div;
    logic          drv_alt, busy, req_reject;

    int checks = 0, fails = 0, cyc = 0;
    string tag = "R1";

    int m_lvl = 0, m_busy = 0, m_rej = 0, m_pend = -1, m_stat = 0, m_dead = 0;

    always #10 clk = ~clk;

    dvfs_seq #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .dyn_en(dyn_en), .fast_base(fast_base),
        .cfg_low(cfg_low), .cfg_high(cfg_high), .static_src(static_src),
        .static_div(static_div), .dwell_len(dwell_len), .req_valid(req_valid),
        .req_ratio(req_ratio), .cur_level(cur_level), .drv_src(drv_src),
        .drv_div(drv_div), .drv_alt(drv_alt), .busy(busy), .req_reject(req_reject)
    );

    function automatic logic [15:0] slot(int dv, int al, int sr);
        return 16'((dv << 13) | (al << 11) | (sr << 9));
    endfunction

    function automatic int fld(int l, int pos, int msk);
        logic [31:0] w;
        int b;
        w = (l < 2) ? cfg_low : cfg_high;
        b = ((l % 2) == 0) ? 16 : 0;
        return int'((w >> (b + pos)) & 32'(msk));
    endfunction

    task automatic expect_v(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", t, act, exp);
        end
    endtask

    // Reference model: updated at each rising edge, compared a quarter period later
    always @(posedge clk) begin
        int tgt, t, dd;
        bit dn;
        cyc++;
        dd = (dwell_len == '0) ? 1 : int'(dwell_len);
        if (!rst_n) begin
            m_lvl = 0; m_busy = 0; m_rej = 0; m_pend = -1; m_stat = 0;
        end else begin
            tgt = -1;
            if (req_valid && dyn_en)
                for (int l = 3; l >= 0; l--)
                    if (fld(l, 13, 7) == int'(req_ratio)) tgt = l;
            m_rej = (req_valid && tgt < 0) ? 1 : 0;
            dn = (m_stat == 2) || (m_stat == 1 && cyc > m_dead);
            if (m_busy == 1) begin
                if (tgt >= 0) m_pend = tgt;
                if (cyc >= m_dead) begin m_lvl = 0; m_busy = 0; m_stat = 0; end
            end else begin
                t = (tgt >= 0) ? tgt : m_pend;
                m_pend = -1;
                if (t >= 0 && t != m_lvl) begin
                    if (t == 1) begin
                        if (m_lvl == 0) m_stat = 2;
                        else begin m_stat = 1; m_dead = cyc + dd; end
                        m_lvl = 1;
                    end else if (t >= 2) begin
                        m_lvl = t; m_stat = 0;
                    end else if (!fast_base || dn) begin
                        m_lvl = 0; m_stat = 0;
                    end else begin
                        m_lvl = 1; m_busy = 1; m_stat = 0; m_dead = cyc + dd;
                    end
                end
            end
        end
        #5;
        checks++;
        if (int'(cur_level) != m_lvl || int'(busy) != m_busy || int'(req_reject) != m_rej ||
            int'(drv_src) != (dyn_en ? fld(m_lvl, 9, 3) : int'(static_src)) ||
            int'(drv_div) != (dyn_en ? fld(m_lvl, 13, 7) : int'(static_div)) ||
            int'(drv_alt) != (dyn_en ? fld(m_lvl, 11, 1) : 0)) begin
            fails++;
            $display("FAIL %s model: actual lvl=%0d busy=%0d rej=%0d src=%0d div=%0d alt=%0d expected lvl=%0d busy=%0d rej=%0d",
                     tag, cur_level, busy, req_reject, drv_src, drv_div, drv_alt, m_lvl, m_busy, m_rej);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send(input int r);
        @(negedge clk);
        req_valid = 1'b1;
        req_ratio = 3'(r);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60 && busy; i++) @(negedge clk);
    endtask

    initial begin
        #4000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        cfg_low  = {slot(1, 1, 2), slot(2, 0, 1)};
        cfg_high = {slot(4, 1, 3), slot(6, 0, 0)};
        repeat (3) step();
        tag = "R1";
        expect_v("R1 level", cur_level, 0);
        expect_v("R1 busy", busy, 0);
        expect_v("R1 reject", req_reject, 0);
        rst_n = 1'b1; dyn_en = 1'b1; fast_base = 1'b1;
        step();

        tag = "R4"; send(4);
        expect_v("R4 resolve ratio 4", cur_level, 2);
        tag = "R2";
        expect_v("R2 src level2", drv_src, 3);
        expect_v("R2 div level2", drv_div, 4);
        expect_v("R2 alt level2", drv_alt, 1);
        tag = "R6"; send(4);
        expect_v("R6 same level", cur_level, 2);
        tag = "R5"; send(7);
        expect_v("R5 reject pulse", req_reject, 1);
        expect_v("R5 level kept", cur_level, 2);
        step();
        expect_v("R5 pulse ends", req_reject, 0);

        tag = "R7"; send(1);
        expect_v("R7 via level1", cur_level, 1);
        expect_v("R7 busy", busy, 1);
        tag = "R12"; send(6); send(2);
        expect_v("R12 still dwelling", cur_level, 1);
        wait_idle();
        expect_v("R12 dwell ends at 0", cur_level, 0);
        step();
        expect_v("R12 newest held applied", cur_level, 1);
        tag = "R2";
        expect_v("R2 src level1", drv_src, 1);
        expect_v("R2 div level1", drv_div, 2);

        tag = "R9"; send(1);
        expect_v("R9 direct to 0", cur_level, 0);
        expect_v("R9 no busy", busy, 0);

        tag = "R10"; send(2); send(4); send(1);
        expect_v("R10 forced dwell", busy, 1);
        wait_idle();
        expect_v("R10 reaches 0", cur_level, 0);

        tag = "R8"; send(6); send(2);
        repeat (8) step();
        send(1);
        expect_v("R8 direct after timer", cur_level, 0);
        expect_v("R8 no busy", busy, 0);

        tag = "R13"; send(4); send(2); send(1);
        expect_v("R13 timer running forces dwell", busy, 1);
        n = 0;
        while (busy && n < 60) begin step(); n++; end
        tag = "R7";
        expect_v("R7 dwell length", n, 5);
        expect_v("R7 ends at 0", cur_level, 0);

        tag = "R11"; fast_base = 1'b0;
        send(6); send(1);
        expect_v("R11 slow base direct", cur_level, 0);
        expect_v("R11 no busy", busy, 0);
        fast_base = 1'b1;

        tag = "R4";
        cfg_high = {slot(4, 1, 3), slot(2, 1, 1)};
        send(2);
        expect_v("R4 lowest match wins", cur_level, 1);

        tag = "R3"; dyn_en = 1'b0; static_src = 2'd2; static_div = 3'd5;
        step();
        expect_v("R3 static src", drv_src, 2);
        expect_v("R3 static div", drv_div, 5);
        expect_v("R3 alt low", drv_alt, 0);
        send(4);
        expect_v("R3 reject", req_reject, 1);
        expect_v("R3 level kept", cur_level, 1);
        dyn_en = 1'b1;

        tag = "R12"; send(4); send(1);
        expect_v("R12 collision dwell start", busy, 1);
        repeat (3) step();
        cfg_high = {slot(4, 1, 3), slot(6, 0, 0)};
        send(6);
        expect_v("R12 collision exit", cur_level, 0);
        step();
        expect_v("R12 collision held applied", cur_level, 3);

        repeat (3) step();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule